// File: doc/BRIEF.md
# Per-Line Edge/Level Interrupt Request Latch

This block turns eight asynchronous interrupt lines into a registered request vector in the local clock domain. Each raw line is first brought through a synchroniser chain. A trigger-mode register then chooses, line by line, how the request bit reacts. In level mode the request bit copies the synchronised line in both directions. In edge mode the bit is set by a low-to-high transition and stays set until a downstream arbiter acknowledges that line.

The trigger-mode register is written as a whole byte. Only bits allowed by a fixed, per-instance writable mask can ever become 1. An acknowledge is a one-cycle strobe carrying a 3-bit line index. The request vector and the trigger-mode register are both visible as outputs, so a priority resolver or a register block can sit next to this latch.

Top module: `irq_req_latch`

## Requirements
- R1: After reset, `req_q` is 0 and `mode_q` is 0, so every line starts in edge mode.
- R2: A cycle with `mode_we` high loads `mode_q` with `mode_wdata & WRITABLE_MASK` (default mask 8'hFB, so bit 2 always reads 0). The new value is visible after that clock edge and governs request updates from the following edge on.
- R3: For a line whose `mode_q` bit is 1 (level mode), the request bit follows the line. A line change that is stable before clock edge k shows up in `req_q` after edge k+2, in both directions.
- R4: For a line whose `mode_q` bit is 0 (edge mode), a low-to-high change that is stable before edge k sets the request bit after edge k+2.
- R5: In edge mode, a falling line does not clear the request bit.
- R6: In edge mode, `ack_stb` high with `ack_idx` = n clears request bit n after that edge. Other bits are unaffected.
- R7: In level mode, an acknowledge has no effect on the request bit.
- R8: If a new rising edge of a line is detected at the same edge at which that line is acknowledged, its request bit stays set.
- R9: After an edge-mode request is acknowledged, a line that stays high does not set it again. Only a new low-to-high change does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw asynchronous interrupt lines |
| mode_we | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata | input | 8 | Trigger-mode write data (1 = level, 0 = edge per line) |
| ack_stb | input | 1 | Acknowledge strobe, one cycle |
| ack_idx | input | 3 | Index of the acknowledged line |
| mode_q | output | 8 | Current trigger-mode register |
| req_q | output | 8 | Request register |

## Verification
A corrupted stored previous level appears at the ports as a missing or extra request bit at the next edge that the line rises or stays high. A wrong trigger-mode bit appears as soon as the line falls or is acknowledged: the request either clears when it should hold, or holds when it should clear. Because every cycle's `req_q` and `mode_q` are compared against an independent reference, any such divergence is reported in the first cycle it becomes visible. That is at most three edges after the stimulus that exposes it.

// File: rtl/irql_pkg.sv
package irql_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Edge detect against the stored previous synchronised level.
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Next value of one request bit.
  function automatic logic next_req_bit(
    input trig_mode_e mode,
    input logic       now_lvl,
    input logic       prev_lvl,
    input logic       req_now,
    input logic       ack_hit
  );
    logic keep;
    if (mode == TRIG_LEVEL) begin
      return now_lvl;
    end
    keep = req_now & ~ack_hit;
    return rise_of(now_lvl, prev_lvl) | keep;
  endfunction

endpackage

// File: rtl/irql_sync.sv
module irql_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[LAST];

  initial begin
    assert (STAGES >= 2) else $error("irql_sync needs at least two stages");
  end
endmodule

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] MASK  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mode_q
);
  logic [WIDTH-1:0] masked_wdata;
  assign masked_wdata = wdata & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)  mode_q <= '0;
    else if (we) mode_q <= masked_wdata;
  end

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode_q == ($past(wdata) & MASK)));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mode_q));
endmodule

// File: rtl/irql_line.sv
module irql_line
  import irql_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_mode,
  input  logic sync_lvl,
  input  logic ack_hit,
  output logic req
);
  trig_mode_e mode;
  logic       prev_lvl;
  logic       rise_evt;
  logic       req_next;

  assign mode     = level_mode ? TRIG_LEVEL : TRIG_EDGE;
  assign rise_evt = rise_of(sync_lvl, prev_lvl);
  assign req_next = next_req_bit(mode, sync_lvl, prev_lvl, req, ack_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lvl <= 1'b0;
      req      <= 1'b0;
    end else begin
      prev_lvl <= sync_lvl;
      req      <= req_next;
    end
  end

  assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode |=> (req == $past(sync_lvl)));

  assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && rise_evt) |=> req);

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && req && !ack_hit) |=> req);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && ack_hit && !rise_evt) |=> !req);

  assert_edge_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !req && !rise_evt) |=> !req);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int                   NUM_LINES     = 8,
  parameter int                   SYNC_STAGES   = 2,
  parameter logic [NUM_LINES-1:0] WRITABLE_MASK = 8'hFB,
  parameter int                   IDX_W         = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 mode_we,
  input  logic [NUM_LINES-1:0] mode_wdata,
  input  logic                 ack_stb,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic [NUM_LINES-1:0] mode_q,
  output logic [NUM_LINES-1:0] req_q
);
  logic [NUM_LINES-1:0] sync_lvl;
  logic [NUM_LINES-1:0] ack_hit;

  irql_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (sync_lvl)
  );

  irql_mode_reg #(.WIDTH(NUM_LINES), .MASK(WRITABLE_MASK)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mode_we),
    .wdata  (mode_wdata),
    .mode_q (mode_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign ack_hit[i] = ack_stb && (ack_idx == IDX_W'(i));

    irql_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_mode (mode_q[i]),
      .sync_lvl   (sync_lvl[i]),
      .ack_hit    (ack_hit[i]),
      .req        (req_q[i])
    );
  end

  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit));

  assert_ack_level_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && mode_q[ack_idx] && sync_lvl[ack_idx]) |=> req_q[$past(ack_idx)]);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (req_q == '0 && mode_q == '0));
endmodule

// File: tb/sim_irq_req_latch.sv
module sim_irq_req_latch;
  localparam logic [7:0] MASK = 8'hFB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       ack_stb = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [7:0] mode_q;
  logic [7:0] req_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_req_latch u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ack_stb(ack_stb), .ack_idx(ack_idx),
    .mode_q(mode_q), .req_q(req_q)
  );

  typedef struct {
    logic [7:0] req;
    logic [7:0] mode;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Reference: line history as a delay line, seen two edges late.
  logic [7:0] hist0 = '0, hist1 = '0, seen_last = '0;
  logic [7:0] m_req = '0, m_mode = '0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] lines, input logic av, input logic [2:0] ai,
                      input logic we, input logic [7:0] wd, input string tag);
    logic [7:0] nr;
    exp_t e;
    @(negedge clk);
    irq_in = lines; ack_stb = av; ack_idx = ai; mode_we = we; mode_wdata = wd;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      if (m_mode[i]) nr[i] = hist1[i];
      else if (hist1[i] && !seen_last[i]) nr[i] = 1'b1;
      else if (av && ai == 3'(i)) nr[i] = 1'b0;
      else nr[i] = m_req[i];
    end
    seen_last = hist1;
    hist1 = hist0;
    hist0 = lines;
    m_req = nr;
    if (we) m_mode = wd & MASK;
    e.req = m_req; e.mode = m_mode; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, req_q, e.req, "req_q");
      check(e.tag, mode_q, e.mode, "mode_q");
    end
  end

  task automatic idle(input int n, input logic [7:0] lines, input string tag);
    for (int k = 0; k < n; k++) step(lines, 1'b0, 3'd0, 1'b0, 8'h00, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", req_q, 8'h00, "req_q after reset");
    check("R1", mode_q, 8'h00, "mode_q after reset");
    rst_n = 1'b1;

    idle(2, 8'h00, "R1");
    // Edge mode: lines 0 and 5 rise.
    idle(5, 8'h21, "R4");
    // Line 0 falls: request must hold.
    idle(4, 8'h20, "R5");
    // Acknowledge line 0 only.
    step(8'h20, 1'b1, 3'd0, 1'b0, 8'h00, "R6");
    idle(2, 8'h20, "R6");
    // Acknowledge line 5 while it stays high: no re-set.
    step(8'h20, 1'b1, 3'd5, 1'b0, 8'h00, "R9");
    idle(4, 8'h20, "R9");
    // Mode write with masked bit 2.
    step(8'h20, 1'b0, 3'd0, 1'b1, 8'hFF, "R2");
    idle(2, 8'h20, "R2");
    // Level mode tracks in both directions, ignores ack.
    idle(4, 8'h03, "R3");
    step(8'h03, 1'b1, 3'd1, 1'b0, 8'h00, "R7");
    idle(2, 8'h03, "R7");
    idle(4, 8'h01, "R3");
    idle(4, 8'h04, "R4");
    // Back to edge mode; line 3 pulse, then a new edge meeting its ack.
    step(8'h00, 1'b0, 3'd0, 1'b1, 8'h00, "R2");
    idle(3, 8'h00, "R2");
    idle(1, 8'h08, "R4");
    idle(4, 8'h00, "R4");
    step(8'h08, 1'b0, 3'd0, 1'b0, 8'h00, "R8");
    step(8'h08, 1'b0, 3'd0, 1'b0, 8'h00, "R8");
    step(8'h08, 1'b1, 3'd3, 1'b0, 8'h00, "R8");
    idle(3, 8'h08, "R8");
    // Mixed stimulus.
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:0], lfsr[8], lfsr[11:9], (lfsr[15:12] == 4'h5), lfsr[15:8], "R4");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule